// File: doc/BRIEF.md
# Debug Clock-Output Selector with Power-of-Two Divider

This block picks one of up to sixteen internal rate strobes. Each strobe is a single-cycle enable that marks one period of some on-chip clock domain. The block thins the chosen strobe by 1, 2, 4, 8 or 16 and drives the result on a debug output pin, but only while the output is enabled. Configuration goes through a small register with three fields: a 4-bit source code, a divide exponent and an enable bit. Software writes a ratio, not an exponent. Any write that names a reserved source code, or a ratio that is not a supported power of two, is refused as a whole. A refused write leaves the register unchanged and raises a one-cycle error flag.

A separate write path touches only the enable bit, so the output can be stopped and restarted without disturbing the chosen source or divide. A combinational rounding helper accepts a wanted ratio in unsigned 8.4 fixed point. It returns the smallest supported power of two that is at or above the ceiling of that ratio, which lets software pick a legal setting before it writes.

Top module: `clkout_sel`

## Requirements
- R1: After a synchronous active-low reset, the source code is 0, the divide exponent is 0, the enable bit is 0, `clk_out` is low and `wr_err` is low.
- R2: An accepted full write stores the source code, the enable bit and the exponent. The ratio maps to the exponent as 1→0, 2→1, 4→2, 8→3 and 16→4. All three stored values can be read on `rd_sel`, `rd_code` and `rd_out_en` from the cycle after the write.
- R3: Source codes 0–3, 5 and 7–12 (0xC) are legal. A full write naming code 4, 6 or 13–15 is refused, and no field changes.
- R4: A full write whose ratio is not 1, 2, 4, 8 or 16 is refused, and no field changes. This includes a ratio of 0.
- R5: While enabled, `clk_out` gives one single-cycle pulse for every 2^exponent strobes on the selected lane. Each pulse comes one cycle after the strobe that completes the group. Strobes on any other lane have no effect.
- R6: An enable-only write sets or clears the enable bit and leaves the source and exponent unchanged. From the cycle after the bit is seen clear, `clk_out` stays low. If a full write arrives in the same cycle, the full write takes priority and the enable-only write is dropped, whether or not the full write is accepted.
- R7: An accepted write that changes the source or the exponent restarts the divider. With the selected lane strobing every cycle, the first pulse appears 2^exponent cycles after the write edge.
- R8: The rounding helper takes the ceiling of the wanted ratio. A ceiling above 8 gives 16, above 4 gives 8, above 2 gives 4, exactly 2 gives 2, and 1 or 0 gives 1.
- R9: `wr_err` is high for exactly the one cycle after a refused full write. It stays low after an accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | Full register write strobe |
| wr_sel | input | 4 | Source code to store |
| wr_ratio | input | 5 | Requested divide ratio (1, 2, 4, 8 or 16) |
| wr_out_en | input | 1 | Enable bit carried by a full write |
| gate_wr | input | 1 | Enable-only write strobe |
| gate_val | input | 1 | Value for the enable bit on an enable-only write |
| src_tick | input | 16 | One rate strobe per source code |
| want_ratio | input | 12 | Wanted ratio for rounding, unsigned 8.4 fixed point |
| rd_sel | output | 4 | Stored source code |
| rd_code | output | 3 | Stored divide exponent |
| rd_out_en | output | 1 | Stored enable bit |
| wr_err | output | 1 | One-cycle flag for a refused full write |
| round_ratio | output | 5 | Rounded power-of-two ratio |
| clk_out | output | 1 | Divided debug output strobe |

## Verification
Two pairs of events can fall in the same cycle. The first is a configuration write landing on the same edge as a strobe on the selected lane, which forces the restart and the count to compete. The bench holds the lane strobing every cycle across each write. It judges the outcome by the exact distance from the write edge to the first output pulse. The second pair is an enable-only write presented together with a full write, once with an accepted full write and once with a refused one. Here the stored enable bit must follow the full write, or stay unchanged when the full write is refused.

// File: rtl/clkout_pkg.sv
// Package: shared constants and the configuration record for the clock-output selector.
// Assumes a 4-bit source code and a maximum divide exponent of 4 (ratio 16).
package clkout_pkg;
    localparam int SEL_W    = 4;
    localparam int NUM_SRC  = 1 << SEL_W;
    localparam int MAX_CODE = 4;
    localparam int CODE_W   = $clog2(MAX_CODE + 1);
    localparam int RATIO_W  = MAX_CODE + 1;
    // One bit per source code: 1 marks a legal code (0-3, 5, 7-12).
    localparam logic [NUM_SRC-1:0] SEL_LEGAL = 16'h1FAF;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [CODE_W-1:0] code;
        logic              en;
    } cfg_t;
endpackage

// File: rtl/clkout_ctrl.sv
// Control register: validates full writes, encodes ratio to exponent,
// applies enable-only writes, flags refused writes for one cycle.
// Assumes write strobes are synchronous to clk.
module clkout_ctrl
    import clkout_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_valid,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [RATIO_W-1:0] wr_ratio,
    input  logic               wr_out_en,
    input  logic               gate_wr,
    input  logic               gate_val,
    output cfg_t               cfg_o,
    output logic               restart_o,
    output logic               err_o
);
    cfg_t              cfg_q;
    logic              sel_ok;
    logic              ratio_ok;
    logic [CODE_W-1:0] code_new;
    logic              accept;

    // Decode the requested ratio into an exponent and check the source code.
    always_comb begin
        ratio_ok = 1'b0;
        code_new = '0;
        for (int k = 0; k <= MAX_CODE; k++) begin
            if (wr_ratio == RATIO_W'(1 << k)) begin
                ratio_ok = 1'b1;
                code_new = CODE_W'(k);
            end
        end
        sel_ok = SEL_LEGAL[wr_sel];
    end

    assign accept    = wr_valid && sel_ok && ratio_ok;
    assign restart_o = accept && ((wr_sel != cfg_q.sel) || (code_new != cfg_q.code));

    // Register update: full write first, enable-only write otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (accept) begin
            cfg_q.sel  <= wr_sel;
            cfg_q.code <= code_new;
            cfg_q.en   <= wr_out_en;
        end else if (gate_wr && !wr_valid) begin
            cfg_q.en <= gate_val;
        end
    end

    // One-cycle error flag for a refused full write.
    always_ff @(posedge clk) begin
        if (!rst_n) err_o <= 1'b0;
        else        err_o <= wr_valid && !accept;
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/clkout_div.sv
// Divider: selects one strobe lane and emits one pulse per 2^code strobes.
// Assumes restart is a single-cycle request; the counter clears on restart or disable.
module clkout_div
    import clkout_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  cfg_t               cfg,
    input  logic               restart,
    input  logic [NUM_SRC-1:0] src_tick,
    output logic               out_o
);
    logic [MAX_CODE-1:0] cnt_q;
    logic [MAX_CODE-1:0] mask;
    logic                tick_sel;
    logic                wrap;

    assign tick_sel = src_tick[cfg.sel];
    assign mask     = MAX_CODE'((32'd1 << cfg.code) - 32'd1);
    assign wrap     = (cnt_q == mask);

    // Count selected strobes; pulse when the group completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            out_o <= 1'b0;
        end else if (restart || !cfg.en) begin
            cnt_q <= '0;
            out_o <= 1'b0;
        end else if (tick_sel) begin
            out_o <= wrap;
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end else begin
            out_o <= 1'b0;
        end
    end
endmodule

// File: rtl/clkout_round.sv
// Rounding helper: ceiling of a fixed-point ratio, snapped up to 2^k, k <= MAX_K.
// Purely combinational; a ceiling of 0 yields ratio 1.
module clkout_round #(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 4,
    parameter int MAX_K  = 4,
    localparam int OUT_W = MAX_K + 1
) (
    input  logic [INT_W+FRAC_W-1:0] want,
    output logic [OUT_W-1:0]        ratio
);
    logic [INT_W:0] ceil_v;

    // Ceiling: bump the integer part when any fractional bit is set.
    assign ceil_v = {1'b0, want[INT_W+FRAC_W-1:FRAC_W]} + (INT_W+1)'(|want[FRAC_W-1:0]);

    // Snap up: the smallest power of two at or above the ceiling wins.
    always_comb begin
        ratio = OUT_W'(1 << MAX_K);
        for (int k = MAX_K; k >= 0; k--) begin
            if (int'(ceil_v) <= (1 << k)) ratio = OUT_W'(1 << k);
        end
    end
endmodule

// File: rtl/clkout_sel.sv
// Top: debug clock-output selector with register, divider and rounding helper.
// Assumes all inputs are synchronous to clk; output is a divided strobe.
module clkout_sel
    import clkout_pkg::*;
#(
    parameter int WANT_INT_W  = 8,
    parameter int WANT_FRAC_W = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_valid,
    input  logic [SEL_W-1:0]               wr_sel,
    input  logic [RATIO_W-1:0]             wr_ratio,
    input  logic                           wr_out_en,
    input  logic                           gate_wr,
    input  logic                           gate_val,
    input  logic [NUM_SRC-1:0]             src_tick,
    input  logic [WANT_INT_W+WANT_FRAC_W-1:0] want_ratio,
    output logic [SEL_W-1:0]               rd_sel,
    output logic [CODE_W-1:0]              rd_code,
    output logic                           rd_out_en,
    output logic                           wr_err,
    output logic [RATIO_W-1:0]             round_ratio,
    output logic                           clk_out
);
    cfg_t cfg;
    logic restart;

    clkout_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_sel    (wr_sel),
        .wr_ratio  (wr_ratio),
        .wr_out_en (wr_out_en),
        .gate_wr   (gate_wr),
        .gate_val  (gate_val),
        .cfg_o     (cfg),
        .restart_o (restart),
        .err_o     (wr_err)
    );

    clkout_div u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg      (cfg),
        .restart  (restart),
        .src_tick (src_tick),
        .out_o    (clk_out)
    );

    clkout_round #(
        .INT_W  (WANT_INT_W),
        .FRAC_W (WANT_FRAC_W),
        .MAX_K  (MAX_CODE)
    ) u_round (
        .want  (want_ratio),
        .ratio (round_ratio)
    );

    assign rd_sel    = cfg.sel;
    assign rd_code   = cfg.code;
    assign rd_out_en = cfg.en;
endmodule

// File: rtl/clkout_sel_chk.sv
// Checker: temporal properties of the clock-output selector, bound to the top.
module clkout_sel_chk
    import clkout_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               wr_valid,
    input logic [NUM_SRC-1:0] src_tick,
    input logic [SEL_W-1:0]   rd_sel,
    input logic [CODE_W-1:0]  rd_code,
    input logic               rd_out_en,
    input logic               wr_err,
    input logic [RATIO_W-1:0] round_ratio,
    input logic               clk_out
);
    assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |=> (!clk_out && !wr_err));

    assert_code_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_code <= CODE_W'(MAX_CODE));

    assert_sel_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        SEL_LEGAL[rd_sel]);

    assert_reject_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> (rd_sel == $past(rd_sel) && rd_code == $past(rd_code)
                    && rd_out_en == $past(rd_out_en)));

    assert_pulse_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clk_out |-> $past(src_tick[rd_sel]));

    assert_gate_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_out_en) |-> !clk_out);

    assert_round_pow2_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(round_ratio) == 1);

    assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(wr_valid));
endmodule

bind clkout_sel clkout_sel_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .src_tick    (src_tick),
    .rd_sel      (rd_sel),
    .rd_code     (rd_code),
    .rd_out_en   (rd_out_en),
    .wr_err      (wr_err),
    .round_ratio (round_ratio),
    .clk_out     (clk_out)
);

// File: tb/test_clkout_sel.sv
module test_clkout_sel;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_valid;
    logic [3:0]  wr_sel;
    logic [4:0]  wr_ratio;
    logic        wr_out_en;
    logic        gate_wr;
    logic        gate_val;
    logic [15:0] src_tick;
    logic [11:0] want_ratio;
    logic [3:0]  rd_sel;
    logic [2:0]  rd_code;
    logic        rd_out_en;
    logic        wr_err;
    logic [4:0]  round_ratio;
    logic        clk_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    clkout_sel i_clkout_sel (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_sel(wr_sel),
        .wr_ratio(wr_ratio), .wr_out_en(wr_out_en), .gate_wr(gate_wr),
        .gate_val(gate_val), .src_tick(src_tick), .want_ratio(want_ratio),
        .rd_sel(rd_sel), .rd_code(rd_code), .rd_out_en(rd_out_en),
        .wr_err(wr_err), .round_ratio(round_ratio), .clk_out(clk_out)
    );

    // Rounding vectors (R8): {wanted 8.4 ratio, expected result}.
    localparam logic [16:0] RVEC [0:14] = '{
        {12'h010, 5'd1},  {12'h018, 5'd2},  {12'h020, 5'd2},  {12'h021, 5'd4},
        {12'h030, 5'd4},  {12'h040, 5'd4},  {12'h041, 5'd8},  {12'h050, 5'd8},
        {12'h080, 5'd8},  {12'h081, 5'd16}, {12'h0C0, 5'd16}, {12'h100, 5'd16},
        {12'hFF0, 5'd16}, {12'h000, 5'd1},  {12'h001, 5'd1}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic full_wr(input int s, input int r, input bit e);
        @(negedge clk);
        wr_valid = 1'b1; wr_sel = 4'(s); wr_ratio = 5'(r); wr_out_en = e;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic gate(input bit v);
        @(negedge clk);
        gate_wr = 1'b1; gate_val = v;
        @(negedge clk);
        gate_wr = 1'b0;
    endtask

    task automatic count_pulses(input int lane, input int win, output int n);
        src_tick = 16'(1 << lane);
        repeat (20) @(negedge clk);
        n = 0;
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            if (clk_out) n++;
        end
    endtask

    task automatic first_pulse(output int at);
        at = 0;
        for (int i = 1; i <= 40; i++) begin
            @(negedge clk);
            if (clk_out && at == 0) at = i;
        end
    endtask

    initial begin
        int n;
        int at;
        int s0, c0;
        rst_n = 1'b0; wr_valid = 0; wr_sel = 0; wr_ratio = 0; wr_out_en = 0;
        gate_wr = 0; gate_val = 0; src_tick = '1; want_ratio = 0;
        repeat (3) @(negedge clk);
        chk(rd_sel == 0 && rd_code == 0 && !rd_out_en, "R1 fields", {rd_sel, rd_code, rd_out_en}, 0);
        chk(!clk_out && !wr_err, "R1 outputs", {clk_out, wr_err}, 0);
        rst_n = 1'b1;
        src_tick = '0;

        // Rounding table (R8)
        for (int v = 0; v < 15; v++) begin
            want_ratio = RVEC[v][16:5];
            #1;
            chk(round_ratio == RVEC[v][4:0], "R8 round", round_ratio, RVEC[v][4:0]);
        end

        // Accepted write and readback (R2, R9)
        full_wr(5, 4, 1);
        chk(rd_sel == 5 && rd_code == 2 && rd_out_en, "R2 readback", {rd_sel, rd_code}, {4'd5, 3'd2});
        chk(!wr_err, "R9 no error on accept", wr_err, 0);
        count_pulses(5, 32, n);
        chk(n == 8, "R5 lane5 div4", n, 8);
        count_pulses(3, 32, n);
        chk(n == 0, "R5 other lane ignored", n, 0);

        // Every exponent on lane 7 (R2, R5)
        for (int c = 0; c <= 4; c++) begin
            full_wr(7, 1 << c, 1);
            chk(rd_code == 3'(c), "R2 ratio encode", rd_code, c);
            count_pulses(7, 32, n);
            chk(n == (32 >> c), "R5 pulse rate", n, 32 >> c);
        end

        // Restart on field change (R7)
        src_tick = 16'(1 << 9);
        full_wr(9, 8, 1);
        first_pulse(at);
        chk(at == 8, "R7 restart sel change", at, 8);
        full_wr(9, 16, 1);
        first_pulse(at);
        chk(at == 16, "R7 restart code change", at, 16);

        // Refused source codes (R3, R9)
        foreach (RVEC[j]) begin end
        for (int k = 0; k < 5; k++) begin
            int bad;
            bad = (k == 0) ? 4 : (k == 1) ? 6 : 12 + k - 1;
            s0 = rd_sel; c0 = rd_code;
            full_wr(bad, 2, 0);
            chk(wr_err, "R9 error on bad source", wr_err, 1);
            chk(rd_sel == 4'(s0) && rd_code == 3'(c0) && rd_out_en, "R3 bad source ignored", rd_sel, s0);
            @(negedge clk);
            chk(!wr_err, "R9 error one cycle", wr_err, 0);
        end

        // Refused ratios (R4)
        for (int k = 0; k < 5; k++) begin
            int badr;
            badr = (k == 0) ? 0 : (k == 1) ? 3 : (k == 2) ? 5 : (k == 3) ? 12 : 31;
            full_wr(2, badr, 0);
            chk(wr_err && rd_sel == 9 && rd_code == 4 && rd_out_en, "R4 bad ratio ignored", rd_code, 4);
        end

        // Enable-only writes (R6)
        full_wr(8, 2, 1);
        gate(0);
        chk(!rd_out_en && rd_sel == 8 && rd_code == 1, "R6 gate off keeps fields", {rd_sel, rd_code}, {4'd8, 3'd1});
        count_pulses(8, 32, n);
        chk(n == 0, "R6 output low when off", n, 0);
        gate(1);
        count_pulses(8, 32, n);
        chk(n == 16, "R6 output resumes", n, 16);

        // Enable-only write together with a full write (R6)
        @(negedge clk);
        wr_valid = 1; wr_sel = 2; wr_ratio = 2; wr_out_en = 1; gate_wr = 1; gate_val = 0;
        @(negedge clk);
        wr_valid = 0; gate_wr = 0;
        chk(rd_out_en && rd_sel == 2, "R6 full write wins", rd_out_en, 1);
        @(negedge clk);
        wr_valid = 1; wr_sel = 6; wr_ratio = 2; wr_out_en = 0; gate_wr = 1; gate_val = 0;
        @(negedge clk);
        wr_valid = 0; gate_wr = 0;
        chk(rd_out_en && rd_sel == 2, "R6 refused write blocks gate", rd_out_en, 1);

        // Reset again (R1)
        @(negedge clk); rst_n = 0;
        @(negedge clk);
        chk(rd_sel == 0 && rd_code == 0 && !rd_out_en && !clk_out, "R1 re-reset", rd_sel, 0);
        rst_n = 1;

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule